// File: doc/BRIEF.md
# Dual-Channel Memory Copy Engine

This block copies data from one memory region to another without processor help. Two independent channels each hold a start source address, a start destination address, a unit count and a control word. Software programs these through a small word-addressed register port. The engine then moves the data over a single-master memory bus. Each bus transfer is held until the memory answers with ready. Every unit is a read from the source followed by a write to the destination.

A channel's control word selects several things. It sets the unit width: one byte, two bytes, four bytes, or a sixteen-byte group carried as four word moves. It sets how each address moves after a unit: it can stay put, step up or step down. It also selects whether the channel runs on its own until its count is used up, or advances one unit per rising edge of its request pin. A shared operation register holds the global run enable and the choice between fixed and alternating channel priority. When a channel finishes, it raises its end flag. If its interrupt enable is set, it also drives the interrupt output with its own 7-bit vector until software clears the flag.

Top module: `dma2_top`

## Requirements
- R1: After reset every register reads zero, `mem_req` is low and `irq` is low.
- R2: Register map, word offsets on `reg_addr`: channel 0 at 0..4 and channel 1 at 8..12, in the order source, destination, count, control, vector. The operation register is at 15, with bit 0 as the global run enable and bit 1 selecting alternating priority. The count holds 24 bits, and bits 31:24 of a count write are dropped.
- R3: A channel issues bus traffic only while the global enable is 1 and its control bits {1,0} (end flag, channel enable) equal 2'b01.
- R4: Control bits 11:10 pick the unit: 0 is 1 byte (`mem_size`=0), 1 is 2 bytes (`mem_size`=1), 2 is 4 bytes (`mem_size`=2) and 3 is 16 bytes. A 16-byte unit is four read/write word pairs at offsets 0, 4, 8 and 12, with `mem_size`=2.
- R5: Control bits 13:12 set the source mode and bits 15:14 set the destination mode: 0 fixed, 1 step up, 2 step down, 3 fixed. The step equals the unit size. In 16-byte mode the source always advances by 16, and the destination moves by 16 in its selected direction.
- R6: With control bit 9 set, the channel runs units back to back. It decrements the count once per unit and sets its end flag when the count reaches zero.
- R7: With control bit 9 clear, the channel performs exactly one unit per rising edge of its `dreq` bit. A level held high gives only one unit.
- R8: An eligible channel whose count is zero sets its end flag at once, with no bus transfer.
- R9: Writing 0 to control bit 1 clears the end flag, and writing 1 leaves it unchanged. While the flag is set, the channel does not restart.
- R10: `irq` is high while any channel has its end flag and its control bit 2 set. `irq_vec` carries channel 0's vector when channel 0 is requesting, and otherwise channel 1's.
- R11: With operation bit 1 clear, channel 0 always wins. With it set, the channels take turns unit by unit, and channel 0 goes first after reset.
- R12: Each bus transfer completes on a cycle with both `mem_req` and `mem_ready` high. Address and direction hold while ready is low, and a completed read is followed directly by its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 2 | Per-channel transfer request pins |
| mem_req | output | 1 | Bus transfer request |
| mem_we | output | 1 | Bus write (1) or read (0) |
| mem_size | output | 2 | Bus access width code |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 32 | Bus write data, right-aligned |
| mem_rdata | input | 32 | Bus read data, right-aligned |
| mem_ready | input | 1 | Bus transfer acknowledge |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 7 | Vector of the requesting channel |

## Verification
The copy function is swept across all four unit widths and all nine pairings of fixed, rising and falling source and destination modes, with a randomly stalling memory. The run compares the whole memory image, the final addresses and the bus transfer count. Together these separate wrong step sizes, wrong directions, a missing 16-byte source advance and a wrong number of beats. Separate runs hold the global enable off, re-set the end flag, use a zero count, pulse or hold the request pin, and race both channels under each priority mode. The ch1 count read at the moment ch0 finishes tells fixed order apart from turn-taking.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  localparam int NCH = 2;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int CW  = 24;
  localparam int VW  = 7;
  localparam int CTLW = 16;

  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_UP    = 2'd1,
    AM_DOWN  = 2'd2,
    AM_HOLD  = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_RD   = 2'd1,
    MV_WR   = 2'd2
  } mv_state_e;

  function automatic logic [4:0] unit_bytes(input logic [1:0] u);
    case (u)
      2'd0:    unit_bytes = 5'd1;
      2'd1:    unit_bytes = 5'd2;
      2'd2:    unit_bytes = 5'd4;
      default: unit_bytes = 5'd16;
    endcase
  endfunction

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] a,
                                            input logic [1:0] mode,
                                            input logic [4:0] step);
    case (amode_e'(mode))
      AM_UP:   advance = a + AW'(step);
      AM_DOWN: advance = a - AW'(step);
      default: advance = a;
    endcase
  endfunction
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
  import dma2_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic            master_en,
  input  logic            dreq,
  input  logic            unit_done,
  output logic            run_req,
  output logic [AW-1:0]   src,
  output logic [AW-1:0]   dst,
  output logic [CW-1:0]   cnt,
  output logic [CTLW-1:0] ctl,
  output logic [VW-1:0]   vec,
  output logic            end_flag,
  output logic            irq_req
);
  localparam int B_EN   = 0;
  localparam int B_END  = 1;
  localparam int B_IE   = 2;
  localparam int B_AUTO = 9;

  logic [AW-1:0]   src_n, dst_n;
  logic [CW-1:0]   cnt_n;
  logic [CTLW-1:0] ctl_n;
  logic [VW-1:0]   vec_n;
  logic            pend_q, pend_n, dreq_q;
  logic            eligible, dreq_rise, burst;
  logic [4:0]      ubytes;

  assign eligible  = master_en & ctl[B_EN] & ~ctl[B_END];
  assign dreq_rise = dreq & ~dreq_q;
  assign burst     = (ctl[11:10] == 2'd3);
  assign ubytes    = unit_bytes(ctl[11:10]);
  assign run_req   = eligible & (cnt != '0) & (ctl[B_AUTO] | pend_q);
  assign end_flag  = ctl[B_END];
  assign irq_req   = ctl[B_END] & ctl[B_IE];

  always_comb begin
    src_n  = src;
    dst_n  = dst;
    cnt_n  = cnt;
    ctl_n  = ctl;
    vec_n  = vec;
    pend_n = pend_q;
    if (unit_done) begin
      src_n  = burst ? advance(src, AM_UP, ubytes) : advance(src, ctl[13:12], ubytes);
      dst_n  = advance(dst, ctl[15:14], ubytes);
      cnt_n  = cnt - 1'b1;
      pend_n = 1'b0;
      if (cnt == CW'(1)) ctl_n[B_END] = 1'b1;
    end else if (eligible && cnt == '0) begin
      ctl_n[B_END] = 1'b1;
    end
    if (dreq_rise && eligible && !ctl[B_AUTO]) pend_n = 1'b1;
    if (wr_en) begin
      case (wr_sel)
        3'd0: src_n = wr_data;
        3'd1: dst_n = wr_data;
        3'd2: cnt_n = wr_data[CW-1:0];
        3'd3: begin
          ctl_n        = wr_data[CTLW-1:0];
          ctl_n[B_END] = ctl[B_END] & wr_data[B_END];
          pend_n       = 1'b0;
        end
        3'd4: vec_n = wr_data[VW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src    <= '0;
      dst    <= '0;
      cnt    <= '0;
      ctl    <= '0;
      vec    <= '0;
      pend_q <= 1'b0;
      dreq_q <= 1'b0;
    end else begin
      src    <= src_n;
      dst    <= dst_n;
      cnt    <= cnt_n;
      ctl    <= ctl_n;
      vec    <= vec_n;
      pend_q <= pend_n;
      dreq_q <= dreq;
    end
  end
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb
  import dma2_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           rr_mode,
  input  logic           pick,
  output logic           gnt,
  output logic           any
);
  logic last_q, last_n;

  assign any = |req;

  always_comb begin
    if (rr_mode && req == 2'b11) gnt = ~last_q;
    else                         gnt = ~req[0];
    last_n = pick ? gnt : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= last_n;
  end
endmodule

// File: rtl/dma2_mover.sv
module dma2_mover
  import dma2_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_any,
  input  logic          gnt,
  input  logic [AW-1:0] src_sel,
  input  logic [AW-1:0] dst_sel,
  input  logic [1:0]    unit_sel,
  output logic          pick,
  output logic          cur_ch,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);
  mv_state_e     st_q, st_n;
  logic [1:0]    beat_q, beat_n;
  logic          ch_q, ch_n;
  logic [DW-1:0] data_q, data_n;
  logic          burst;
  logic [AW-1:0] off;

  assign burst     = (unit_sel == 2'd3);
  assign off       = burst ? AW'({beat_q, 2'b00}) : '0;
  assign cur_ch    = ch_q;
  assign mem_req   = (st_q != MV_IDLE);
  assign mem_we    = (st_q == MV_WR);
  assign mem_size  = burst ? 2'd2 : unit_sel;
  assign mem_addr  = ((st_q == MV_WR) ? dst_sel : src_sel) + off;
  assign mem_wdata = data_q;

  always_comb begin
    st_n   = st_q;
    beat_n = beat_q;
    ch_n   = ch_q;
    data_n = data_q;
    pick   = 1'b0;
    done   = 1'b0;
    case (st_q)
      MV_IDLE: if (req_any) begin
        pick   = 1'b1;
        ch_n   = gnt;
        beat_n = 2'd0;
        st_n   = MV_RD;
      end
      MV_RD: if (mem_ready) begin
        data_n = mem_rdata;
        st_n   = MV_WR;
      end
      MV_WR: if (mem_ready) begin
        if (burst && beat_q != 2'd3) begin
          beat_n = beat_q + 2'd1;
          st_n   = MV_RD;
        end else begin
          done = 1'b1;
          st_n = MV_IDLE;
        end
      end
      default: st_n = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MV_IDLE;
      beat_q <= '0;
      ch_q   <= 1'b0;
      data_q <= '0;
    end else begin
      st_q   <= st_n;
      beat_q <= beat_n;
      ch_q   <= ch_n;
      data_q <= data_n;
    end
  end
endmodule

// File: rtl/dma2_top.sv
module dma2_top
  import dma2_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [1:0]    dreq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ready,
  output logic          irq,
  output logic [6:0]    irq_vec
);
  localparam logic [3:0] OPR_ADDR = 4'd15;

  logic [1:0]      rsync_q;
  logic            rst_i;
  logic [1:0]      opr_q, opr_n;
  logic [NCH-1:0]  run_req, unit_done, irq_req, te_bits, ie_bits;
  logic [AW-1:0]   src_a [NCH];
  logic [AW-1:0]   dst_a [NCH];
  logic [CW-1:0]   cnt_a [NCH];
  logic [CTLW-1:0] ctl_a [NCH];
  logic [VW-1:0]   vec_a [NCH];
  logic            gnt, any, pick, cur_ch, done;
  logic [CW-1:0]   cnt0, cnt1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  always_comb begin
    opr_n = opr_q;
    if (reg_we && reg_addr == OPR_ADDR) opr_n = reg_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) opr_q <= '0;
    else        opr_q <= opr_n;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wr_hit;
    assign wr_hit       = reg_we && (reg_addr[3] == 1'(i)) && (reg_addr[2:0] <= 3'd4);
    assign unit_done[i] = done && (cur_ch == 1'(i));
    assign te_bits[i]   = ctl_a[i][1];
    assign ie_bits[i]   = ctl_a[i][2];
    dma2_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_i),
      .wr_en     (wr_hit),
      .wr_sel    (reg_addr[2:0]),
      .wr_data   (reg_wdata),
      .master_en (opr_q[0]),
      .dreq      (dreq[i]),
      .unit_done (unit_done[i]),
      .run_req   (run_req[i]),
      .src       (src_a[i]),
      .dst       (dst_a[i]),
      .cnt       (cnt_a[i]),
      .ctl       (ctl_a[i]),
      .vec       (vec_a[i]),
      .end_flag  (),
      .irq_req   (irq_req[i])
    );
  end

  assign cnt0 = cnt_a[0];
  assign cnt1 = cnt_a[1];

  dma2_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_i),
    .req     (run_req),
    .rr_mode (opr_q[1]),
    .pick    (pick),
    .gnt     (gnt),
    .any     (any)
  );

  dma2_mover u_mover (
    .clk       (clk),
    .rst_n     (rst_i),
    .req_any   (any),
    .gnt       (gnt),
    .src_sel   (src_a[cur_ch]),
    .dst_sel   (dst_a[cur_ch]),
    .unit_sel  (ctl_a[cur_ch][11:10]),
    .pick      (pick),
    .cur_ch    (cur_ch),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_size  (mem_size),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OPR_ADDR) begin
      reg_rdata = {30'd0, opr_q};
    end else begin
      case (reg_addr[2:0])
        3'd0: reg_rdata = src_a[reg_addr[3]];
        3'd1: reg_rdata = dst_a[reg_addr[3]];
        3'd2: reg_rdata = {{(32-CW){1'b0}}, cnt_a[reg_addr[3]]};
        3'd3: reg_rdata = {{(32-CTLW){1'b0}}, ctl_a[reg_addr[3]]};
        3'd4: reg_rdata = {{(32-VW){1'b0}}, vec_a[reg_addr[3]]};
        default: reg_rdata = '0;
      endcase
    end
  end

  assign irq     = |irq_req;
  assign irq_vec = irq_req[0] ? vec_a[0] : (irq_req[1] ? vec_a[1] : '0);
endmodule

// File: rtl/dma2_checker.sv
module dma2_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ready,
  input logic [1:0]  mem_size,
  input logic [31:0] mem_addr,
  input logic [1:0]  te_bits,
  input logic [23:0] cnt0,
  input logic [23:0] cnt1
);
  a_r12_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r12_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ready |=> mem_req && mem_we);

  a_r4_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_size != 2'd3);

  a_r6_end_ch0_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te_bits[0]) |-> cnt0 == 24'd0);

  a_r6_end_ch1_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te_bits[1]) |-> cnt1 == 24'd0);
endmodule

bind dma2_top dma2_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_i),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ready (mem_ready),
  .mem_size  (mem_size),
  .mem_addr  (mem_addr),
  .te_bits   (te_bits),
  .cnt0      (cnt0),
  .cnt1      (cnt1)
);

// File: tb/dma2_top_test.sv
module dma2_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  dreq = '0;
  logic        mem_req, mem_we, mem_ready, irq;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [6:0]  irq_vec;
  logic [7:0]  lfsr = 8'hA5;

  logic [7:0]  mem  [0:1023];
  logic [7:0]  refm [0:1023];
  int checks = 0, errors = 0, xfers = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma2_top uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .irq(irq), .irq_vec(irq_vec)
  );

  logic [9:0] ma;
  assign ma = mem_addr[9:0];
  assign mem_rdata = {mem[ma + 10'd3], mem[ma + 10'd2], mem[ma + 10'd1], mem[ma]};
  assign mem_ready = lfsr[0] | lfsr[1];

  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mem_req && mem_ready) begin
      xfers = xfers + 1;
      if (mem_we) begin
        for (int b = 0; b < (mem_size == 2'd0 ? 1 : (mem_size == 2'd1 ? 2 : 4)); b++)
          mem[ma + 10'(b)] = mem_wdata[8*b +: 8];
      end
    end
    if (cyc > 150000 && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_end(input logic [3:0] base);
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      rd(base + 4'd3, v);
      if (v[1]) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill();
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 8'(i * 7 + 3) ^ 8'(i >> 3);
      refm[i] = mem[i];
    end
  endtask

  // R4 R5 R6: one sweep point, count 3, channel 0
  task automatic sweep(input int unit, input int sm, input int dm);
    logic [31:0] s, d, v, s0, d0;
    int nb, x0, bad;
    nb = (unit == 3) ? 16 : (1 << unit);
    s0 = 32'h100; d0 = 32'h300;
    s = s0; d = d0;
    fill();
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < nb; b++) refm[10'(d + 32'(b))] = refm[10'(s + 32'(b))];
      if (unit == 3) s = s + 16;
      else if (sm == 1) s = s + 32'(nb);
      else if (sm == 2) s = s - 32'(nb);
      if (dm == 1) d = d + 32'(nb);
      else if (dm == 2) d = d - 32'(nb);
    end
    wr(4'd0, s0); wr(4'd1, d0); wr(4'd2, 32'd3);
    x0 = xfers;
    wr(4'd3, (dm << 14) | (sm << 12) | (unit << 10) | (1 << 9) | 1);
    wait_end(4'd0);
    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== refm[i]) bad++;
    chk(bad == 0, $sformatf("R4/R5 data unit=%0d sm=%0d dm=%0d", unit, sm, dm), bad, 0);
    rd(4'd0, v); chk(v == s, $sformatf("R5 final src unit=%0d sm=%0d", unit, sm), v, s);
    rd(4'd1, v); chk(v == d, $sformatf("R5 final dst unit=%0d dm=%0d", unit, dm), v, d);
    rd(4'd2, v); chk(v == 0, "R6 count drained", v, 0);
    chk(xfers - x0 == ((unit == 3) ? 24 : 6), $sformatf("R4 bus beats unit=%0d", unit),
        xfers - x0, (unit == 3) ? 24 : 6);
    wr(4'd3, 32'd0);
  endtask

  // R11: race both channels, return ch1 count when ch0 ends
  task automatic race(input bit rr, output logic [31:0] c1);
    logic [31:0] v;
    wr(4'd15, 32'd0);
    wr(4'd0, 32'h000); wr(4'd1, 32'h200); wr(4'd2, 32'd4);
    wr(4'd8, 32'h080); wr(4'd9, 32'h280); wr(4'd10, 32'd4);
    wr(4'd3, (1 << 12) | (1 << 14) | (2 << 10) | (1 << 9) | 1);
    wr(4'd11, (1 << 12) | (1 << 14) | (2 << 10) | (1 << 9) | 1);
    wr(4'd15, {30'd0, rr, 1'b1});
    c1 = 32'hFFFF_FFFF;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      rd(4'd3, v);
      if (v[1]) begin rd(4'd10, c1); break; end
    end
    wait_end(4'd8);
    wr(4'd3, 32'd0); wr(4'd11, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    int x0;
    fill();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk(v == 0, $sformatf("R1 reg %0d after reset", a), v, 0);
    end
    chk(irq == 0 && mem_req == 0, "R1 irq/mem_req idle", {irq, mem_req}, 0);

    // R2 count width
    wr(4'd2, 32'hFF00_0005); rd(4'd2, v);
    chk(v == 32'd5, "R2 count upper bits dropped", v, 5);

    // R3 global enable off: nothing moves
    x0 = xfers;
    wr(4'd3, (2 << 10) | (1 << 9) | 1);
    idle(30);
    rd(4'd2, v);
    chk(xfers == x0 && v == 5, "R3 no traffic without global enable", xfers - x0, 0);
    wr(4'd3, 32'd0);
    wr(4'd15, 32'd1);

    // R4 R5 R6 sweep
    for (int u = 0; u < 4; u++)
      for (int sm = 0; sm < 3; sm++)
        for (int dm = 0; dm < 3; dm++)
          sweep(u, sm, dm);

    // R8 zero count
    x0 = xfers;
    wr(4'd2, 32'd0);
    wr(4'd3, (1 << 9) | 1);
    idle(3);
    rd(4'd3, v);
    chk(v[1] == 1'b1, "R8 zero count ends at once", v, 32'h203);
    chk(xfers == x0, "R8 zero count no bus transfer", xfers - x0, 0);

    // R9 end flag blocks restart
    wr(4'd0, 32'h100); wr(4'd1, 32'h300); wr(4'd2, 32'd2);
    idle(20);
    rd(4'd2, v);
    chk(xfers == x0 && v == 2, "R9 end flag blocks restart", xfers - x0, 0);
    wr(4'd3, (1 << 9) | 3);
    idle(20);
    rd(4'd3, v);
    chk(xfers == x0 && v[1], "R9 writing 1 keeps end flag", v, 32'h203);
    wr(4'd3, (1 << 9) | 1);
    wait_end(4'd0);
    rd(4'd2, v);
    chk(v == 0, "R9 restart after clear", v, 0);
    wr(4'd3, 32'd0);

    // R7 request pin on channel 1
    x0 = xfers;
    wr(4'd8, 32'h040); wr(4'd9, 32'h240); wr(4'd10, 32'd3);
    wr(4'd11, (1 << 12) | (1 << 14) | (2 << 10) | 1);
    idle(20);
    chk(xfers == x0, "R7 waits for request edge", xfers - x0, 0);
    @(negedge clk); dreq[1] = 1'b1; @(negedge clk); dreq[1] = 1'b0;
    idle(40);
    rd(4'd10, v);
    chk(v == 2, "R7 one unit per pulse", v, 2);
    @(negedge clk); dreq[1] = 1'b1;
    idle(40);
    rd(4'd10, v);
    chk(v == 1, "R7 held level gives one unit", v, 1);
    dreq[1] = 1'b0;
    idle(2);
    @(negedge clk); dreq[1] = 1'b1; @(negedge clk); dreq[1] = 1'b0;
    idle(40);
    rd(4'd11, v);
    chk(v[1] == 1'b1, "R7 last pulse ends channel", v[1], 1);
    wr(4'd11, 32'd0);

    // R10 interrupt and vectors
    wr(4'd4, 32'h55); wr(4'd2, 32'd1);
    wr(4'd3, 4 | (1 << 9) | 1);
    wait_end(4'd0);
    chk(irq == 1 && irq_vec == 7'h55, "R10 irq with ch0 vector", {irq, irq_vec}, {1'b1, 7'h55});
    wr(4'd3, 32'd0);
    chk(irq == 0, "R10 irq drops on clear", irq, 0);
    wr(4'd3, 32'h4);
    chk(irq == 0, "R10 no irq without end flag", irq, 0);
    wr(4'd4, 32'h11); wr(4'd12, 32'h22);
    wr(4'd2, 32'd1); wr(4'd10, 32'd1);
    wr(4'd3, 4 | (1 << 9) | 1); wr(4'd11, 4 | (1 << 9) | 1);
    wait_end(4'd0); wait_end(4'd8);
    chk(irq_vec == 7'h11, "R10 ch0 vector first", irq_vec, 7'h11);
    wr(4'd3, 32'd0);
    chk(irq == 1 && irq_vec == 7'h22, "R10 ch1 vector after ch0 clear", irq_vec, 7'h22);
    wr(4'd11, 32'd0);

    // R11 priority
    race(1'b0, v);
    chk(v == 4, "R11 fixed priority holds ch1", v, 4);
    race(1'b1, v);
    chk(v == 1, "R11 alternating priority", v, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule